// File: doc/BRIEF.md
# Interrupt Arbitration and Trap Entry Unit

This unit keeps the machine status word and the four exception registers (saved exception PC, handler vector, trap cause, faulting address). Every cycle it checks whether an exception request or an unmasked, enabled interrupt is present. If one is, it performs the whole trap entry in a single clock edge. It saves the current PC, records the cause, moves the privilege and enable bits into their "previous" slots, enters supervisor mode with interrupts off, cancels any load reservation, and presents a redirect to the handler vector on the next cycle.

Software reaches the registers through a simple write port and a registered read port. The unit also reports the current privilege level and the active 64-bit width mode. The width mode comes from the supervisor-width bit while in supervisor mode and from the user-width bit otherwise.

Status word layout, with NIRQ = 8:

| Bits | Field |
|------|-------|
| 0 | supervisor |
| 1 | previous supervisor |
| 2 | interrupt enable |
| 3 | previous enable |
| 4 | supervisor 64-bit |
| 5 | user 64-bit |
| 6 | translation on |
| 7 | reserved |
| [15:8] | interrupt mask |
| [23:16] | interrupt pending |
| above 23 | reserved |

Register addresses are 0 status, 1 exception PC, 2 vector, 3 cause and 4 bad address. The bad-address register is read-only.

Top module: `trap_unit`

## Requirements
- R1: While reset is held, and until the first clock edge after its release, redirect_valid is 1 and redirect_pc is 0x2000. Out of reset the status word reads 0x31 (supervisor, supervisor 64-bit and user 64-bit set; enable and translation clear), and the exception PC, vector, cause and bad-address registers read 0.
- R2: An interrupt trap is taken only when the enable bit (bit 2) is 1 and the AND of the mask field and the pending field is nonzero. The pending field is irq_pend registered once.
- R3: When several pending and unmasked interrupts exist, the lowest-numbered one is taken.
- R4: The cause of an interrupt is its index plus a top bit. The top bit is bit 63 when the supervisor 64-bit bit is set before the trap, and bit 31 otherwise.
- R5: On any trap, the previous-supervisor bit receives the old supervisor bit and the previous-enable bit receives the old enable bit. Then supervisor becomes 1 and enable becomes 0.
- R6: On any trap, the exception PC register takes pc_in and the cause register is written. In the next cycle redirect_valid is 1 and redirect_pc holds the vector register's value. An exception (exc_req) records exc_cause as the cause and exc_addr as the bad address.
- R7: If an interrupt and exc_req occur in the same cycle, the interrupt is taken and the bad-address register keeps its value. A register write presented in a trap cycle is discarded.
- R8: A status write leaves the pending field unchanged: it still reflects irq_pend.
- R9: A write to the vector register stores the data with bits [1:0] forced to 0.
- R10: wide_mode equals the supervisor 64-bit bit when supervisor is 1, and the user 64-bit bit otherwise. priv_sup equals the supervisor bit.
- R11: Any trap clears resv_valid, including one in the same cycle as resv_set. Otherwise resv_set sets resv_valid.
- R12: Reserved status bits (bit 7 and bits above the pending field) read as 0 whatever is written to them.
- R13: csr_rdata shows, one cycle after csr_raddr is presented, the register value from the cycle of the request. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| pc_in | input | XLEN | PC of the instruction in the trap slot |
| exc_req | input | 1 | synchronous exception request |
| exc_cause | input | XLEN | cause code of the exception |
| exc_addr | input | XLEN | faulting address of the exception |
| irq_pend | input | NIRQ | per-source interrupt pending lines |
| csr_we | input | 1 | register write strobe |
| csr_waddr | input | 3 | register write address |
| csr_wdata | input | XLEN | register write data |
| csr_raddr | input | 3 | register read address |
| csr_rdata | output | XLEN | registered read data |
| resv_set | input | 1 | sets the load reservation |
| resv_valid | output | 1 | load reservation outstanding |
| redirect_valid | output | 1 | fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | restart address |
| priv_sup | output | 1 | supervisor mode active |
| wide_mode | output | 1 | 64-bit width mode active |

## Verification
Properties checked on every cycle:
- An exception request is always followed by supervisor mode, a redirect and a dropped reservation.
- A cycle with no exception and no registered pending line never produces a redirect.
- Vector reads always show two zero low bits.
- Status reads always show zero reserved bits.

Only the bench scenarios show the following, because each needs a planned sequence of register writes before it:
- lowest-index selection
- the cause's top-bit position under each width setting
- the previous-state swap
- interrupt-over-exception priority
- the discarding of a write in a trap cycle

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned B_SUP    = 0;
  localparam int unsigned B_PSUP   = 1;
  localparam int unsigned B_IEN    = 2;
  localparam int unsigned B_PIEN   = 3;
  localparam int unsigned B_S64    = 4;
  localparam int unsigned B_U64    = 5;
  localparam int unsigned B_VM     = 6;
  localparam int unsigned MASK_LSB = 8;

  localparam logic [2:0] RA_STATUS = 3'd0;
  localparam logic [2:0] RA_EPC    = 3'd1;
  localparam logic [2:0] RA_EVEC   = 3'd2;
  localparam logic [2:0] RA_CAUSE  = 3'd3;
  localparam logic [2:0] RA_BAD    = 3'd4;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]                    req,
  output logic                            any,
  output logic [(N > 1 ? $clog2(N) : 1)-1:0] idx
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic [NIRQ-1:0] pend_in,
  output logic            sup,
  output logic            s64,
  output logic            u64,
  output logic [NIRQ-1:0] armed,
  output logic [XLEN-1:0] word
);
  localparam int unsigned PEND_LSB = MASK_LSB + NIRQ;
  localparam logic [XLEN-1:0] NIRQ_ONES = (XLEN'(1) << NIRQ) - XLEN'(1);
  localparam logic [XLEN-1:0] WR_MASK  = XLEN'(7'h7F) | (NIRQ_ONES << MASK_LSB);
  localparam logic [XLEN-1:0] RST_WORD = (XLEN'(1) << B_SUP) | (XLEN'(1) << B_S64)
                                       | (XLEN'(1) << B_U64);

  logic [XLEN-1:0] st_q;
  logic [NIRQ-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RST_WORD;
      pend_q <= '0;
    end else begin
      pend_q <= pend_in;
      if (take) begin
        st_q[B_SUP]  <= 1'b1;
        st_q[B_PSUP] <= st_q[B_SUP];
        st_q[B_IEN]  <= 1'b0;
        st_q[B_PIEN] <= st_q[B_IEN];
      end else if (wr_en) begin
        st_q <= wr_data & WR_MASK;
      end
    end
  end

  assign sup   = st_q[B_SUP];
  assign s64   = st_q[B_S64];
  assign u64   = st_q[B_U64];
  assign armed = pend_q & st_q[MASK_LSB +: NIRQ] & {NIRQ{st_q[B_IEN]}};

  always_comb begin
    word = st_q;
    word[PEND_LSB +: NIRQ] = pend_q;
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            keep_bad,
  input  logic [XLEN-1:0] epc_in,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] bad_in,
  input  logic            wr_epc,
  input  logic            wr_evec,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] evec,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] bad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      epc   <= '0;
      evec  <= '0;
      cause <= '0;
      bad   <= '0;
    end else if (take) begin
      epc   <= epc_in;
      cause <= cause_in;
      if (!keep_bad) bad <= bad_in;
    end else begin
      if (wr_epc)  epc  <= wr_data;
      if (wr_evec) evec <= {wr_data[XLEN-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NIRQ     = 8,
  parameter logic [63:0] RESET_PC = 64'h2000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_in,
  input  logic            exc_req,
  input  logic [XLEN-1:0] exc_cause,
  input  logic [XLEN-1:0] exc_addr,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            csr_we,
  input  logic [2:0]      csr_waddr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [2:0]      csr_raddr,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            resv_set,
  output logic            resv_valid,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            priv_sup,
  output logic            wide_mode
);
  localparam int unsigned IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int unsigned TOP = XLEN - 1;

  logic            sup, s64, u64, irq_any, take, wr_ok;
  logic [NIRQ-1:0] armed;
  logic [IW-1:0]   irq_idx;
  logic [XLEN-1:0] st_word, epc, evec, cause, bad, irq_cause, cause_in;

  trap_status #(.XLEN(XLEN), .NIRQ(NIRQ)) u_status (
    .clk(clk), .rst(rst), .take(take),
    .wr_en(wr_ok && csr_waddr == RA_STATUS), .wr_data(csr_wdata),
    .pend_in(irq_pend), .sup(sup), .s64(s64), .u64(u64),
    .armed(armed), .word(st_word)
  );

  irq_pick #(.N(NIRQ)) u_pick (.req(armed), .any(irq_any), .idx(irq_idx));

  assign take      = irq_any | exc_req;
  assign wr_ok     = csr_we & ~take;
  assign irq_cause = (s64 ? (XLEN'(1) << TOP) : (XLEN'(1) << 31)) | XLEN'(irq_idx);
  assign cause_in  = irq_any ? irq_cause : exc_cause;

  trap_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst(rst), .take(take), .keep_bad(irq_any),
    .epc_in(pc_in), .cause_in(cause_in), .bad_in(exc_addr),
    .wr_epc(wr_ok && csr_waddr == RA_EPC),
    .wr_evec(wr_ok && csr_waddr == RA_EVEC),
    .wr_data(csr_wdata),
    .epc(epc), .evec(evec), .cause(cause), .bad(bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b1;
      redirect_pc    <= XLEN'(RESET_PC);
      resv_valid     <= 1'b0;
      csr_rdata      <= '0;
    end else begin
      redirect_valid <= take;
      if (take) redirect_pc <= evec;
      resv_valid <= ~take & (resv_valid | resv_set);
      case (csr_raddr)
        RA_STATUS: csr_rdata <= st_word;
        RA_EPC:    csr_rdata <= epc;
        RA_EVEC:   csr_rdata <= evec;
        RA_CAUSE:  csr_rdata <= cause;
        RA_BAD:    csr_rdata <= bad;
        default:   csr_rdata <= '0;
      endcase
    end
  end

  assign priv_sup  = sup;
  assign wide_mode = sup ? s64 : u64;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NIRQ = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_req,
  input logic [NIRQ-1:0] irq_pend,
  input logic [2:0]      csr_raddr,
  input logic [XLEN-1:0] csr_rdata,
  input logic            resv_valid,
  input logic            redirect_valid,
  input logic            priv_sup
);
  localparam int unsigned PEND_TOP = MASK_LSB + 2 * NIRQ;

  // R5: an exception always lands in supervisor mode with a redirect
  a_r5_trap_sup: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (priv_sup && redirect_valid));

  // R11: a trap drops the reservation
  a_r11_resv_drop: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !resv_valid);

  // R2: with no exception and no registered pending line there is no trap
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && $past(irq_pend) == '0) |=> !redirect_valid);

  // R9: vector reads have clear low bits
  a_r9_vec_align: assert property (@(posedge clk) disable iff (rst)
    ($past(csr_raddr) == RA_EVEC) |-> (csr_rdata[1:0] == 2'b00));

  // R12: reserved status bits read zero
  a_r12_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(csr_raddr) == RA_STATUS) |->
      (csr_rdata[7] == 1'b0 && (csr_rdata >> PEND_TOP) == '0));
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst(rst), .exc_req(exc_req), .irq_pend(irq_pend),
  .csr_raddr(csr_raddr), .csr_rdata(csr_rdata), .resv_valid(resv_valid),
  .redirect_valid(redirect_valid), .priv_sup(priv_sup)
);

// File: tb/sim_trap_unit.sv
module sim_trap_unit;
  localparam int HALF = 10;

  logic        clk = 0, rst = 1;
  logic [63:0] pc_in = 0, exc_cause = 0, exc_addr = 0, csr_wdata = 0;
  logic        exc_req = 0, csr_we = 0, resv_set = 0;
  logic [7:0]  irq_pend = 0;
  logic [2:0]  csr_waddr = 0, csr_raddr = 0;
  logic [63:0] csr_rdata, redirect_pc;
  logic        resv_valid, redirect_valid, priv_sup, wide_mode;

  int total = 0, bad = 0;
  bit done = 0, started = 0;

  always #HALF clk = ~clk;

  trap_unit u0 (
    .clk(clk), .rst(rst), .pc_in(pc_in), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_addr(exc_addr), .irq_pend(irq_pend), .csr_we(csr_we), .csr_waddr(csr_waddr),
    .csr_wdata(csr_wdata), .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
    .resv_set(resv_set), .resv_valid(resv_valid), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .priv_sup(priv_sup), .wide_mode(wide_mode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit          m_sup, m_psup, m_ien, m_pien, m_s64, m_u64, m_vm, m_rv, m_resv, hit, tk;
  logic [7:0]  m_mask, m_pend;
  logic [63:0] m_epc, m_evec, m_cause, m_bad, m_rpc, m_rd, n_rd;
  int          pick;

  function automatic logic [63:0] mstat();
    logic [63:0] w = 0;
    w[0] = m_sup; w[1] = m_psup; w[2] = m_ien; w[3] = m_pien;
    w[4] = m_s64; w[5] = m_u64; w[6] = m_vm;
    w[15:8] = m_mask; w[23:16] = m_pend;
    return w;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_sup = 1; m_psup = 0; m_ien = 0; m_pien = 0; m_s64 = 1; m_u64 = 1; m_vm = 0;
      m_mask = 0; m_pend = 0; m_epc = 0; m_evec = 0; m_cause = 0; m_bad = 0;
      m_rv = 1; m_rpc = 64'h2000; m_resv = 0; m_rd = 0;
    end else begin
      case (csr_raddr)
        3'd0: n_rd = mstat();
        3'd1: n_rd = m_epc;
        3'd2: n_rd = m_evec;
        3'd3: n_rd = m_cause;
        3'd4: n_rd = m_bad;
        default: n_rd = 0;
      endcase
      hit = 0; pick = 0;
      for (int i = 7; i >= 0; i--)
        if (m_ien && m_pend[i] && m_mask[i]) begin hit = 1; pick = i; end
      tk = hit || exc_req;
      if (tk) begin
        if (hit) m_cause = (64'd1 << (m_s64 ? 63 : 31)) | 64'(pick);
        else begin m_cause = exc_cause; m_bad = exc_addr; end
        m_epc = pc_in; m_rpc = m_evec; m_rv = 1; m_resv = 0;
        m_psup = m_sup; m_pien = m_ien; m_sup = 1; m_ien = 0;
      end else begin
        m_rv = 0;
        m_resv = m_resv | resv_set;
        if (csr_we) begin
          case (csr_waddr)
            3'd0: begin
              m_sup = csr_wdata[0]; m_psup = csr_wdata[1]; m_ien = csr_wdata[2];
              m_pien = csr_wdata[3]; m_s64 = csr_wdata[4]; m_u64 = csr_wdata[5];
              m_vm = csr_wdata[6]; m_mask = csr_wdata[15:8];
            end
            3'd1: m_epc = csr_wdata;
            3'd2: m_evec = {csr_wdata[63:2], 2'b00};
            default: ;
          endcase
        end
      end
      m_pend = irq_pend;
      m_rd = n_rd;
    end
  end

  always @(posedge clk) begin
    #2;
    if (started) begin
      chk("R6 redirect_valid", 64'(redirect_valid), 64'(m_rv));
      if (m_rv) chk("R6 redirect_pc", redirect_pc, m_rpc);
      chk("R5 priv_sup", 64'(priv_sup), 64'(m_sup));
      chk("R10 wide_mode", 64'(wide_mode), 64'(m_sup ? m_s64 : m_u64));
      chk("R11 resv_valid", 64'(resv_valid), 64'(m_resv));
      chk("R13 csr_rdata", csr_rdata, m_rd);
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    csr_raddr = a; tick(); v = csr_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    csr_we = 1; csr_waddr = a; csr_wdata = d; tick(); csr_we = 0;
  endtask

  logic [63:0] v;

  initial begin
    repeat (3) tick();
    chk("R1 redirect_valid in reset", 64'(redirect_valid), 64'd1);
    chk("R1 redirect_pc in reset", redirect_pc, 64'h2000);
    rst = 0;
    rd(3'd0, v); chk("R1 status reset", v, 64'h31);
    rd(3'd1, v); chk("R1 epc reset", v, 0);
    rd(3'd2, v); chk("R1 evec reset", v, 0);
    rd(3'd3, v); chk("R1 cause reset", v, 0);
    rd(3'd4, v); chk("R1 bad reset", v, 0);
    rd(3'd6, v); chk("R13 unused address", v, 0);

    wr(3'd2, 64'h1003);
    rd(3'd2, v); chk("R9 evec low bits", v, 64'h1000);

    wr(3'd0, '1);
    rd(3'd0, v); chk("R12 reserved bits", v, 64'hFF7F);

    wr(3'd0, 64'h00); chk("R10 user narrow", 64'(wide_mode), 0);
    wr(3'd0, 64'h20); chk("R10 user wide", 64'(wide_mode), 1);
    wr(3'd0, 64'h01); chk("R10 sup narrow", 64'(wide_mode), 0);
    wr(3'd0, 64'h31); chk("R10 sup wide", 64'(wide_mode), 1);

    irq_pend = 8'h0A; tick();
    wr(3'd0, 64'h00FF_0031);
    rd(3'd0, v); chk("R8 pending kept", v, 64'h000A_0031);

    wr(3'd0, 64'h34);
    pc_in = 64'h4444; exc_req = 1; exc_cause = 5; exc_addr = 64'hDEAD;
    tick(); exc_req = 0;
    chk("R6 exception redirect", 64'(redirect_valid), 1);
    chk("R6 exception target", redirect_pc, 64'h1000);
    rd(3'd0, v); chk("R5 status swap", v, 64'h000A_0039);
    rd(3'd1, v); chk("R6 epc", v, 64'h4444);
    rd(3'd3, v); chk("R6 cause", v, 5);
    rd(3'd4, v); chk("R6 bad address", v, 64'hDEAD);

    irq_pend = 8'h0C; tick();
    wr(3'd0, 64'h34); tick(); tick();
    chk("R2 masked no trap", 64'(redirect_valid), 0);
    wr(3'd0, 64'hFF30); tick();
    chk("R2 disabled no trap", 64'(redirect_valid), 0);
    pc_in = 64'h5550;
    wr(3'd0, 64'h0C35); tick();
    chk("R2 interrupt taken", 64'(redirect_valid), 1);
    rd(3'd3, v); chk("R3 R4 lowest index wide cause", v, 64'h8000_0000_0000_0002);
    rd(3'd1, v); chk("R6 interrupt epc", v, 64'h5550);
    rd(3'd0, v); chk("R5 status after irq", v, 64'h000C_0C3B);

    wr(3'd0, 64'h0824); tick();
    rd(3'd3, v); chk("R4 narrow cause", v, 64'h8000_0003);
    rd(3'd0, v); chk("R5 status narrow irq", v, 64'h000C_0829);
    chk("R10 after narrow trap", 64'(wide_mode), 0);

    irq_pend = 8'h01; tick();
    wr(3'd0, 64'h0135);
    exc_req = 1; exc_cause = 7; exc_addr = 64'hBEEF; pc_in = 64'h6000;
    csr_we = 1; csr_waddr = 3'd2; csr_wdata = 64'h9000;
    tick(); exc_req = 0; csr_we = 0;
    chk("R7 redirect target", redirect_pc, 64'h1000);
    rd(3'd3, v); chk("R7 interrupt wins", v, 64'h8000_0000_0000_0000);
    rd(3'd4, v); chk("R7 bad address kept", v, 64'hDEAD);
    rd(3'd2, v); chk("R7 write dropped", v, 64'h1000);
    rd(3'd1, v); chk("R7 epc", v, 64'h6000);

    resv_set = 1; tick(); resv_set = 0;
    chk("R11 reservation set", 64'(resv_valid), 1);
    exc_req = 1; tick(); exc_req = 0;
    chk("R11 trap cancels", 64'(resv_valid), 0);
    resv_set = 1; exc_req = 1; tick(); resv_set = 0; exc_req = 0;
    chk("R11 trap beats set", 64'(resv_valid), 0);

    for (int k = 0; k < 600; k++) begin
      exc_req   = ($urandom % 8) == 0;
      exc_cause = {$urandom, $urandom};
      exc_addr  = {$urandom, $urandom};
      pc_in     = {$urandom, $urandom};
      irq_pend  = 8'($urandom);
      csr_we    = ($urandom % 3) == 0;
      csr_waddr = 3'($urandom);
      csr_wdata = {$urandom, $urandom};
      csr_raddr = 3'($urandom);
      resv_set  = ($urandom % 4) == 0;
      tick();
    end
    exc_req = 0; csr_we = 0; resv_set = 0;
    tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(2 * HALF * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule